// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits beside a receive data path and watches the bytes of one incoming frame. From the first six bytes (the destination address) it decides whether the frame is broadcast or multicast. It counts the bytes of the frame and compares the count with a programmable maximum. At the end of the frame it combines two inputs, the leftover bit count and the CRC verdict, with the promiscuous-mode setting and the verdict of an external address recognition block. From these it produces the status flags and the length for the descriptor that closes the frame.

The data bytes are forwarded unchanged on the same cycle, up to a hard ceiling of 2047 bytes per frame. Bytes past that ceiling are dropped. Address filtering, CRC computation and buffer management belong to neighbouring blocks. Those blocks supply `crc_bad` and `addr_hit` and consume `stat_vld`, `stat_flags` and `stat_len`.

Top module: `rx_frame_classifier`

## Requirements
- R1: `stat_flags[0]` (broadcast) is 1 when the first six bytes of the frame all equal 0xFF. A frame shorter than six bytes is never broadcast.
- R2: `stat_flags[1]` (multicast) is 1 when bit 0 of the first byte of the frame is 1 and the frame is not broadcast.
- R3: `stat_len` reports the number of bytes in the frame, saturating at 2047.
- R4: For bytes 1 to 2047 of a frame, `fwd_vld` equals `in_vld` in the same cycle and `fwd_data` equals `in_data`. From byte 2048 on, `fwd_vld` stays 0.
- R5: `stat_flags[2]` (length violation) is 1 when the frame's true byte count is greater than `max_len`. This includes every frame longer than 2047 bytes.
- R6: `stat_flags[3]` (non-octet) is `crc_bad` AND (`tail_bits` != 0). `stat_flags[4]` (CRC error) is `crc_bad` AND (`tail_bits` == 0), so bits 3 and 4 are never both 1. Both inputs are taken on the end-of-frame byte.
- R7: `stat_flags[5]` (miss) is `promisc_en` AND NOT `addr_hit`, taken on the end-of-frame byte. It is 0 on an address hit and 0 when promiscuous mode is off.
- R8: A byte with `in_vld` and `in_eof` set causes `stat_vld` to pulse for exactly one cycle on the next cycle. The flags and length are updated in that same cycle and then held.
- R9: A byte with `in_sof` set and `in_eof` clear clears `stat_flags` and `stat_len` to 0 on the next cycle.
- R10: During reset (`rst_n` low at a clock edge), `stat_vld`, `stat_flags` and `stat_len` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_eof | input | 1 | This byte is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| tail_bits | input | 3 | Bits received after the last full byte, valid with in_eof |
| crc_bad | input | 1 | CRC at the last byte boundary failed, valid with in_eof |
| max_len | input | LEN_W | Programmed maximum frame length in bytes |
| promisc_en | input | 1 | Promiscuous mode enabled |
| addr_hit | input | 1 | External address recognition matched, valid with in_eof |
| fwd_vld | output | 1 | Forwarded byte valid |
| fwd_data | output | 8 | Forwarded byte |
| stat_vld | output | 1 | One-cycle pulse: status of the finished frame is ready |
| stat_flags | output | 6 | {miss, crc, non-octet, length, multicast, broadcast} |
| stat_len | output | LEN_W | Frame length in bytes, saturated |

## Verification
The bench sends frames whose first byte is 0xFF but whose address is not all ones. A design that keys broadcast on the first byte only would mark these as broadcast; one that fails to exclude broadcast from multicast would raise both flags. It also sends frames shorter than six bytes of 0xFF, which a design without the length guard would call broadcast. Frame lengths equal to and one above `max_len` are used to catch an off-by-one comparison. A 2100-byte frame catches a wrapping counter, leaks of bytes beyond the ceiling, and a missed violation when `max_len` is 2047. All four combinations of tail bits and CRC verdict are covered, as are both promiscuous and hit settings. Single-byte frames are included, as are idle gaps within a frame.

// File: rtl/rfsc_pkg.sv
// Shared definitions for the receive frame status classifier.
package rfsc_pkg;
    localparam int FLAG_W = 6;
    localparam int DA_BYTES = 6;

    // Status flags; bcast lands on bit 0, miss on bit 5.
    typedef struct packed {
        logic miss;
        logic crc;
        logic nonoct;
        logic lenv;
        logic mcast;
        logic bcast;
    } rx_stat_t;
endpackage

// File: rtl/rfsc_len_counter.sv
// Byte counter of one frame.
// Counts accepted bytes, saturates at 2**LEN_W-1, and remembers if the
// true count went past that ceiling. It also gates forwarding of bytes
// beyond the ceiling.
// Assumes in_sof is set only together with in_vld.
module rfsc_len_counter #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             sof,
    output logic [LEN_W-1:0] cnt_nxt,
    output logic             ovf_nxt,
    output logic             fwd_ok
);
    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt_q;
    logic             ovf_q;
    logic [LEN_W-1:0] base;
    logic             base_ovf;

    // Start of frame restarts the count from zero.
    always_comb begin
        base     = sof ? '0 : cnt_q;
        base_ovf = sof ? 1'b0 : ovf_q;
    end

    // Next count with saturation; overflow when a byte arrives at the ceiling.
    always_comb begin
        cnt_nxt = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
        ovf_nxt = base_ovf | (base == CNT_MAX);
        fwd_ok  = byte_vld && (base != CNT_MAX);
    end

    // Hold the count between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (byte_vld) begin
            cnt_q <= cnt_nxt;
            ovf_q <= ovf_nxt;
        end
    end

    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !sof && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    p_drop_past_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && byte_vld && !sof) |-> !fwd_ok);
endmodule

// File: rtl/rfsc_da_check.sv
// Destination address inspector.
// Tracks whether the first DA_BYTES bytes of a frame are all 0xFF.
// Also captures the group bit, which is bit 0 of the first byte.
// Assumes in_sof marks the first byte of the frame.
module rfsc_da_check
    import rfsc_pkg::*;
#(
    parameter int N_DA = DA_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic       sof,
    input  logic [7:0] byte_data,
    output logic       bcast_nxt,
    output logic       grp_nxt
);
    localparam int IDX_W = $clog2(N_DA + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(N_DA);

    logic [IDX_W-1:0] idx_q, idx_nxt, base_idx;
    logic             ff_q, ff_nxt, grp_q;

    // Per-byte update of the address state, restarted on start of frame.
    always_comb begin
        base_idx = sof ? '0 : idx_q;
        ff_nxt   = sof ? 1'b1 : ff_q;
        grp_nxt  = grp_q;
        idx_nxt  = base_idx;
        if (base_idx != IDX_END) begin
            ff_nxt  = ff_nxt & (byte_data == 8'hFF);
            idx_nxt = base_idx + 1'b1;
            if (base_idx == '0) grp_nxt = byte_data[0];
        end
        bcast_nxt = ff_nxt && (idx_nxt == IDX_END);
    end

    // Register the address state on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ff_q  <= 1'b0;
            grp_q <= 1'b0;
        end else if (byte_vld) begin
            idx_q <= idx_nxt;
            ff_q  <= ff_nxt;
            grp_q <= grp_nxt;
        end
    end

    p_da_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !sof && idx_q == IDX_END) |=> ($stable(ff_q) && $stable(grp_q)));
endmodule

// File: rtl/rx_frame_classifier.sv
// Receive frame status classifier (top).
// Builds the closing-descriptor status of a frame: broadcast, multicast,
// length violation, non-octet, CRC error and promiscuous miss, plus the
// saturated byte length. Forwards data bytes up to the length ceiling.
// Assumes in_sof/in_eof/tail_bits/crc_bad/addr_hit are meaningful only
// when in_vld is high.
module rx_frame_classifier
    import rfsc_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic [2:0]       tail_bits,
    input  logic             crc_bad,
    input  logic [LEN_W-1:0] max_len,
    input  logic             promisc_en,
    input  logic             addr_hit,
    output logic             fwd_vld,
    output logic [7:0]       fwd_data,
    output logic             stat_vld,
    output logic [FLAG_W-1:0] stat_flags,
    output logic [LEN_W-1:0] stat_len
);
    logic [LEN_W-1:0] cnt_nxt;
    logic             ovf_nxt;
    logic             bcast_nxt, grp_nxt;
    rx_stat_t         stat_q, stat_d;
    logic [LEN_W-1:0] len_q;
    logic             vld_q;
    logic             start_only, close;

    rfsc_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (in_vld),
        .sof      (in_sof),
        .cnt_nxt  (cnt_nxt),
        .ovf_nxt  (ovf_nxt),
        .fwd_ok   (fwd_vld)
    );

    rfsc_da_check #(.N_DA(DA_BYTES)) u_da (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (in_vld),
        .sof       (in_sof),
        .byte_data (in_data),
        .bcast_nxt (bcast_nxt),
        .grp_nxt   (grp_nxt)
    );

    assign fwd_data = in_data;

    // Decode end and start events of the current byte.
    always_comb begin
        close      = in_vld && in_eof;
        start_only = in_vld && in_sof && !in_eof;
    end

    // Combine the dependent flag rules for the closing descriptor.
    always_comb begin
        stat_d.bcast  = bcast_nxt;
        stat_d.mcast  = grp_nxt && !bcast_nxt;
        stat_d.lenv   = ovf_nxt || (cnt_nxt > max_len);
        stat_d.nonoct = crc_bad && (tail_bits != 3'd0);
        stat_d.crc    = crc_bad && (tail_bits == 3'd0);
        stat_d.miss   = promisc_en && !addr_hit;
    end

    // Latch status at end of frame, clear it at start of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            len_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= close;
            if (close) begin
                stat_q <= stat_d;
                len_q  <= cnt_nxt;
            end else if (start_only) begin
                stat_q <= '0;
                len_q  <= '0;
            end
        end
    end

    assign stat_vld   = vld_q;
    assign stat_flags = stat_q;
    assign stat_len   = len_q;

    p_mc_not_bc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flags[1] |-> !stat_flags[0]);

    p_nonoct_not_crc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flags[3] |-> !stat_flags[4]);

    p_hit_no_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (close && addr_hit) |=> !stat_flags[5]);

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && !close) |=> !stat_vld);

    p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_only |=> (stat_flags == '0 && stat_len == '0 && !stat_vld));
endmodule

// File: tb/rx_frame_classifier_tb.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module rx_frame_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 11;
    localparam int CEIL = 2047;

    logic clk = 1'b0;
    logic rst_n;
    logic in_vld, in_sof, in_eof, crc_bad, promisc_en, addr_hit;
    logic [7:0] in_data;
    logic [2:0] tail_bits;
    logic [LW-1:0] max_len;
    logic fwd_vld, stat_vld;
    logic [7:0] fwd_data;
    logic [5:0] stat_flags;
    logic [LW-1:0] stat_len;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    bit live = 0;

    // Reference model state.
    int  m_cnt = 0;
    int  m_idx = 0;
    bit  m_ff = 0;
    bit  m_grp = 0;
    bit  e_vld = 0;
    bit [5:0] e_flags = '0;
    int  e_len = 0;

    logic [7:0] fq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_classifier #(.LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .tail_bits(tail_bits), .crc_bad(crc_bad), .max_len(max_len),
        .promisc_en(promisc_en), .addr_hit(addr_hit), .fwd_vld(fwd_vld), .fwd_data(fwd_data),
        .stat_vld(stat_vld), .stat_flags(stat_flags), .stat_len(stat_len)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Reference model: updates on the same edges the design samples.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_idx = 0; m_ff = 0; m_grp = 0;
            e_vld = 0; e_flags = '0; e_len = 0;
        end else begin
            e_vld = 0;
            if (in_vld) begin
                if (in_sof) begin m_cnt = 0; m_idx = 0; m_ff = 1; end
                m_cnt++;
                if (m_idx < 6) begin
                    if (m_idx == 0) m_grp = in_data[0];
                    m_ff = m_ff && (in_data == 8'hFF);
                    m_idx++;
                end
                if (in_eof) begin
                    e_vld = 1;
                    e_flags[0] = m_ff && (m_idx == 6);
                    e_flags[1] = m_grp && !e_flags[0];
                    e_flags[2] = (m_cnt > int'(max_len));
                    e_flags[3] = crc_bad && (tail_bits != 0);
                    e_flags[4] = crc_bad && (tail_bits == 0);
                    e_flags[5] = promisc_en && !addr_hit;
                    e_len = (m_cnt > CEIL) ? CEIL : m_cnt;
                end else if (in_sof) begin
                    e_flags = '0; e_len = 0;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            bit exp_fwd;
            exp_fwd = in_vld && (in_sof || m_cnt < CEIL);
            chk(stat_vld == e_vld, "R8 stat_vld", stat_vld, e_vld);
            chk(stat_flags[0] == e_flags[0], "R1 broadcast", stat_flags[0], e_flags[0]);
            chk(stat_flags[1] == e_flags[1], "R2 multicast", stat_flags[1], e_flags[1]);
            chk(stat_flags[2] == e_flags[2], "R5 length violation", stat_flags[2], e_flags[2]);
            chk(stat_flags[4:3] == e_flags[4:3], "R6 nonoct/crc", stat_flags[4:3], e_flags[4:3]);
            chk(stat_flags[5] == e_flags[5], "R7 miss", stat_flags[5], e_flags[5]);
            chk(int'(stat_len) == e_len, "R3 length (R9 clear)", stat_len, e_len);
            chk(fwd_vld == exp_fwd, "R4 fwd_vld", fwd_vld, exp_fwd);
            if (exp_fwd) chk(fwd_data == in_data, "R4 fwd_data", fwd_data, in_data);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Fill the frame queue: mode 0 unicast, 1 broadcast, 2 multicast, 3 FF-led non-broadcast.
    task automatic build(input int n, input int mode);
        fq.delete();
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'(i * 7 + 3);
            if (i < 6) begin
                case (mode)
                    0: b = (i == 0) ? 8'h02 : 8'(8'h10 + i);
                    1: b = 8'hFF;
                    2: b = (i == 0) ? 8'h01 : 8'(8'h5E + i);
                    default: b = (i == 4) ? 8'hFE : 8'hFF;
                endcase
            end
            fq.push_back(b);
        end
    endtask

    task automatic send(input bit [2:0] tb_, input bit cb, input bit pe, input bit hit, input bit gaps);
        for (int i = 0; i < fq.size(); i++) begin
            in_vld = 1; in_data = fq[i];
            in_sof = (i == 0); in_eof = (i == fq.size() - 1);
            tail_bits = tb_; crc_bad = cb; promisc_en = pe; addr_hit = hit;
            tick();
            if (gaps && (i % 3 == 1)) begin
                in_vld = 0; in_sof = 0; in_eof = 0; in_data = 8'hA5;
                tick();
            end
        end
        in_vld = 0; in_sof = 0; in_eof = 0;
        tick();
        tick();
    endtask

    initial begin
        rst_n = 0; in_vld = 0; in_sof = 0; in_eof = 0; in_data = 0;
        tail_bits = 0; crc_bad = 0; promisc_en = 0; addr_hit = 0; max_len = 11'd1518;
        repeat (3) tick();
        chk(stat_vld == 0, "R10 reset stat_vld", stat_vld, 0);
        chk(stat_flags == 0, "R10 reset flags", stat_flags, 0);
        chk(stat_len == 0, "R10 reset len", stat_len, 0);
        rst_n = 1;
        live = 1;
        tick();

        build(64, 1); send(0, 0, 0, 1, 0);          // R1 broadcast
        build(64, 2); send(0, 0, 0, 1, 1);          // R2 multicast with gaps
        build(64, 0); send(0, 0, 0, 1, 0);          // unicast
        build(70, 3); send(0, 0, 0, 1, 0);          // R1/R2 FF-led, not broadcast
        build(5, 1);  send(0, 0, 0, 1, 0);          // R1 short all-FF
        build(1, 1);  send(0, 0, 0, 1, 0);          // single-byte frame
        max_len = 11'd80;
        build(80, 0); send(0, 0, 0, 1, 0);          // R5 equal to max
        build(81, 0); send(0, 0, 0, 1, 0);          // R5 one above max
        max_len = 11'd1518;
        build(40, 0); send(3'd0, 1, 0, 1, 0);       // R6 crc error
        build(40, 0); send(3'd5, 1, 0, 1, 0);       // R6 non-octet
        build(40, 0); send(3'd2, 0, 0, 1, 0);       // R6 tail bits, good crc
        build(40, 0); send(3'd0, 0, 1, 0, 0);       // R7 miss
        build(40, 0); send(3'd0, 0, 1, 1, 0);       // R7 hit in promiscuous
        build(40, 0); send(3'd0, 0, 0, 0, 0);       // R7 promiscuous off
        max_len = 11'd2047;
        build(2100, 2); send(0, 0, 0, 1, 0);        // R3/R4/R5 beyond ceiling
        build(2047, 0); send(0, 0, 0, 1, 0);        // R3 exactly at ceiling
        build(30, 1); send(0, 0, 0, 1, 0);          // after long frame, R9 clear path

        finish_run();
    end
endmodule